// File: doc/BRIEF.md
# FLASH Page Write Sequencer

This block takes byte writes from a host register bus and turns them into write cycles on a parallel FLASH device. The host fills a 256-byte page buffer one byte at a time. It builds an 18-bit device address from three byte-wide register writes. It can also push single bytes to the device through a data port. Every device write, whether issued directly or as part of a page, uses the same timing: chip-enable and write-enable go low together for a fixed number of clocks, then stay high for a fixed recovery gap.

A page transfer begins only after the host has sent the device's three unlock command cycles through the data port. The host then writes the upper address field. That write both completes the start address and launches the transfer. The sequencer then writes the buffered bytes to consecutive device addresses and raises a done bit after the last one.

Afterwards the host polls the device for completion by watching data bit 6 until it stops toggling. That polling happens outside this block. While a page is being streamed, the block drops host writes to the address registers, the buffer and the data port.

Top module: `flash_page_writer`

## Requirements
- R1: After reset, `flash_we_n` and `flash_ce_n` are 1, `page_sent` is 0, and `flash_addr` and `flash_dq` are 0.
- R2: Host register selects are: 0 = command, 1 = buffer data, 2 = address low byte, 3 = address middle byte, 4 = address upper field, 5 = address clear, 6 = FLASH data port. A command write with data bit 0 set returns the buffer fill pointer to 0. Each buffer-data write stores its byte at the pointer and advances the pointer. The pointer wraps after 256 bytes, so byte 257 overwrites position 0.
- R3: The 18-bit address register takes bits 7:0 from select 2, bits 15:8 from select 3, and bits 17:16 from data bits 1:0 of select 4.
- R4: A write to select 5 sets the whole address register to zero.
- R5: A data-port write made while no page stream is active and no write cycle is in progress produces exactly one device write cycle. The cycle drives the current address register on `flash_addr` and the written byte on `flash_dq`. `flash_we_n` and `flash_ce_n` are low for exactly PULSE_CYC (4) clocks and then high for at least GAP_CYC (2) clocks. A data-port write made while a cycle is in progress is dropped.
- R6: A page stream starts only on an upper-field write that follows three consecutive device write cycles: data 0xAA at address 0x05555, then data 0x55 at address 0x02AAA, then data 0xA0 at address 0x05555. An upper-field write without that sequence only updates the address.
- R7: A page stream produces 256 device write cycles. Cycle i writes buffer byte i to address (start + i) modulo 2^18, where start is the address register value including the triggering upper-field write. Each cycle uses the R5 pulse timing.
- R8: `page_sent` goes to 0 in the cycle after the triggering write. It goes to 1 after the recovery gap of the last streamed byte, and it stays 1 until the next stream starts.
- R9: While a stream is active, writes to the address registers, the buffer, the buffer pointer and the data port have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_wr | input | 1 | Host register write strobe |
| host_sel | input | 3 | Host register select (encoding in R2) |
| host_wdata | input | 8 | Host write data |
| flash_addr | output | 18 | FLASH address |
| flash_dq | output | 8 | FLASH write data |
| flash_we_n | output | 1 | FLASH write enable, active low |
| flash_ce_n | output | 1 | FLASH chip enable, active low |
| page_sent | output | 1 | Page stream complete |

## Verification
Some properties are checked by assertions on every clock:
- the write-enable low time: it never exceeds PULSE_CYC and always ends at exactly PULSE_CYC;
- the frozen address register during a stream;
- the buffer pointer advancing by one on each accepted write;
- a stream starting only from an armed unlock state;
- the done bit rising only as a stream ends.

Other behaviour can only be shown by the bench's scenarios. It records every device cycle and compares its address and data with a scoreboard. The scenarios cover:
- the data and address of each streamed byte, including an address wrap and a buffer-pointer wrap;
- a dropped back-to-back data-port write;
- an incomplete unlock sequence that must not launch a stream;
- the proof that writes made during a stream changed neither the address nor the buffer contents.

// File: rtl/flash_pw_pkg.sv
// Shared definitions for the FLASH page write sequencer.
// Assumes a byte-wide host bus and an 18-bit device address.
package flash_pw_pkg;
    typedef enum logic [2:0] {
        SEL_CMD  = 3'd0,
        SEL_BUF  = 3'd1,
        SEL_ALO  = 3'd2,
        SEL_AMID = 3'd3,
        SEL_AHI  = 3'd4,
        SEL_ACLR = 3'd5,
        SEL_DATA = 3'd6
    } host_sel_e;

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_PULSE,
        PH_GAP
    } wphase_e;

    localparam logic [17:0] UNLK_ADDR_A = 18'h05555;
    localparam logic [17:0] UNLK_ADDR_B = 18'h02AAA;
    localparam logic [7:0]  UNLK_D1     = 8'hAA;
    localparam logic [7:0]  UNLK_D2     = 8'h55;
    localparam logic [7:0]  UNLK_D3     = 8'hA0;
endpackage

// File: rtl/page_buffer.sv
// Page staging memory with an auto-advancing fill pointer.
// Assumes the clear and write requests never arrive in the same cycle.
// The read port is combinational and indexed by the streaming logic.
module page_buffer #(
    parameter int DEPTH  = 256,
    parameter int DATA_W = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     clr,
    input  logic                     wr_en,
    input  logic [DATA_W-1:0]        wr_data,
    input  logic [$clog2(DEPTH)-1:0] rd_idx,
    output logic [DATA_W-1:0]        rd_data
);
    localparam int PTR_W = $clog2(DEPTH);

    logic [DATA_W-1:0] mem [DEPTH];
    logic [PTR_W-1:0]  wr_ptr;

    // Fill pointer: cleared on command, advanced on each stored byte.
    always_ff @(posedge clk) begin
        if (!rst_n)     wr_ptr <= '0;
        else if (clr)   wr_ptr <= '0;
        else if (wr_en) wr_ptr <= wr_ptr + 1'b1;
    end

    // Storage: writes one byte at the fill pointer.
    always_ff @(posedge clk) begin
        if (wr_en) mem[wr_ptr] <= wr_data;
    end

    assign rd_data = mem[rd_idx];

    a_r2_ptr_advance: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !clr) |=> (wr_ptr == PTR_W'($past(wr_ptr) + 1'b1)));
endmodule

// File: rtl/unlock_tracker.sv
// Watches accepted device write cycles for the three-step unlock sequence.
// Raises armed after the third step; consume returns it to the start.
// Any cycle that breaks the order restarts the match.
module unlock_tracker #(
    parameter int ADDR_W = 18
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              valid,
    input  logic              consume,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [7:0]        wr_data,
    output logic              armed
);
    import flash_pw_pkg::*;

    logic [1:0] step;
    logic is1, is2, is3;

    // Step matchers for the three command cycles.
    always_comb begin
        is1 = (wr_addr == ADDR_W'(UNLK_ADDR_A)) && (wr_data == UNLK_D1);
        is2 = (wr_addr == ADDR_W'(UNLK_ADDR_B)) && (wr_data == UNLK_D2);
        is3 = (wr_addr == ADDR_W'(UNLK_ADDR_A)) && (wr_data == UNLK_D3);
    end

    // Sequence position: advances on a matching cycle, restarts otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)       step <= 2'd0;
        else if (consume) step <= 2'd0;
        else if (valid) begin
            case (step)
                2'd1:    step <= is2 ? 2'd2 : (is1 ? 2'd1 : 2'd0);
                2'd2:    step <= is3 ? 2'd3 : (is1 ? 2'd1 : 2'd0);
                default: step <= is1 ? 2'd1 : 2'd0;
            endcase
        end
    end

    assign armed = (step == 2'd3);
endmodule

// File: rtl/flash_cycle_engine.sv
// Generates one timed device write cycle per start request.
// Latches address and data, holds write-enable low for PULSE_CYC clocks,
// then keeps it high for GAP_CYC clocks. Assumes start only while idle.
module flash_cycle_engine #(
    parameter int ADDR_W    = 18,
    parameter int DATA_W    = 8,
    parameter int PULSE_CYC = 4,
    parameter int GAP_CYC   = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic [DATA_W-1:0] data_in,
    output logic [ADDR_W-1:0] addr_out,
    output logic [DATA_W-1:0] data_out,
    output logic              we_n,
    output logic              ce_n,
    output logic              busy,
    output logic              cyc_done
);
    import flash_pw_pkg::*;

    localparam int MAXC  = (PULSE_CYC > GAP_CYC) ? PULSE_CYC : GAP_CYC;
    localparam int CNT_W = $clog2(MAXC + 1);

    wphase_e          phase;
    logic [CNT_W-1:0] cnt;

    // Phase sequencing: idle, strobe low, recovery gap.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= PH_IDLE;
            cnt   <= '0;
        end else begin
            case (phase)
                PH_IDLE: if (start) begin
                    phase <= PH_PULSE;
                    cnt   <= CNT_W'(PULSE_CYC - 1);
                end
                PH_PULSE: if (cnt == '0) begin
                    phase <= PH_GAP;
                    cnt   <= CNT_W'(GAP_CYC - 1);
                end else cnt <= cnt - 1'b1;
                PH_GAP: if (cnt == '0) phase <= PH_IDLE;
                        else cnt <= cnt - 1'b1;
                default: phase <= PH_IDLE;
            endcase
        end
    end

    // Output latches: hold address and data for the whole cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_out <= '0;
            data_out <= '0;
        end else if (start && phase == PH_IDLE) begin
            addr_out <= addr_in;
            data_out <= data_in;
        end
    end

    assign we_n     = (phase != PH_PULSE);
    assign ce_n     = (phase != PH_PULSE);
    assign busy     = (phase != PH_IDLE);
    assign cyc_done = (phase == PH_GAP) && (cnt == '0);

    // Checker: counts consecutive low clocks of the write strobe.
    logic [CNT_W:0] chk_len;
    always_ff @(posedge clk) begin
        if (!rst_n)    chk_len <= '0;
        else if (!we_n) chk_len <= (chk_len == '1) ? chk_len : chk_len + 1'b1;
        else           chk_len <= '0;
    end

    a_r5_pulse_max: assert property (@(posedge clk) disable iff (!rst_n)
        !we_n |-> (chk_len < (CNT_W+1)'(PULSE_CYC)));
    a_r5_pulse_exact: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(we_n) |-> (chk_len == (CNT_W+1)'(PULSE_CYC)));
endmodule

// File: rtl/flash_page_writer.sv
// Top of the FLASH page write sequencer.
// Decodes host register writes, assembles the device address, qualifies
// the page launch with the unlock tracker and steps through the buffer
// one timed write cycle at a time. Assumes one host write per strobe.
module flash_page_writer #(
    parameter int ADDR_W     = 18,
    parameter int PAGE_BYTES = 256,
    parameter int PULSE_CYC  = 4,
    parameter int GAP_CYC    = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_wr,
    input  logic [2:0]        host_sel,
    input  logic [7:0]        host_wdata,
    output logic [ADDR_W-1:0] flash_addr,
    output logic [7:0]        flash_dq,
    output logic              flash_we_n,
    output logic              flash_ce_n,
    output logic              page_sent
);
    import flash_pw_pkg::*;

    localparam int PTR_W = $clog2(PAGE_BYTES);
    localparam int HI_W  = ADDR_W - 16;

    logic              wr_cmd, wr_buf, wr_lo, wr_mid, wr_hi, wr_clr, wr_data;
    logic              streaming, owned, armed, trigger;
    logic              eng_busy, eng_done, eng_start, direct_start, stream_start;
    logic [PTR_W-1:0]  idx;
    logic [ADDR_W-1:0] addr_reg, eng_addr;
    logic [7:0]        buf_rd, eng_data;

    // Host decode: one strobe per register select.
    always_comb begin
        wr_cmd  = host_wr && (host_sel == SEL_CMD);
        wr_buf  = host_wr && (host_sel == SEL_BUF);
        wr_lo   = host_wr && (host_sel == SEL_ALO);
        wr_mid  = host_wr && (host_sel == SEL_AMID);
        wr_hi   = host_wr && (host_sel == SEL_AHI);
        wr_clr  = host_wr && (host_sel == SEL_ACLR);
        wr_data = host_wr && (host_sel == SEL_DATA);
    end

    // Cycle requests: direct data-port writes or the next page byte.
    always_comb begin
        trigger      = wr_hi && armed && !streaming;
        direct_start = wr_data && !streaming && !eng_busy;
        stream_start = streaming && !eng_busy;
        eng_start    = direct_start || stream_start;
        eng_addr     = streaming ? addr_reg + ADDR_W'(idx) : addr_reg;
        eng_data     = streaming ? buf_rd : host_wdata;
    end

    // Address register: byte-field updates, frozen during a stream.
    always_ff @(posedge clk) begin
        if (!rst_n) addr_reg <= '0;
        else if (!streaming) begin
            if (wr_clr)      addr_reg <= '0;
            else if (wr_lo)  addr_reg[7:0]         <= host_wdata;
            else if (wr_mid) addr_reg[15:8]        <= host_wdata;
            else if (wr_hi)  addr_reg[ADDR_W-1:16] <= host_wdata[HI_W-1:0];
        end
    end

    // Stream control: walks the page index and reports completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            streaming <= 1'b0;
            idx       <= '0;
            page_sent <= 1'b0;
            owned     <= 1'b0;
        end else begin
            if (eng_start) owned <= stream_start;
            if (trigger) begin
                streaming <= 1'b1;
                idx       <= '0;
                page_sent <= 1'b0;
            end else if (streaming && eng_done && owned) begin
                if (idx == PTR_W'(PAGE_BYTES - 1)) begin
                    streaming <= 1'b0;
                    page_sent <= 1'b1;
                end else idx <= idx + 1'b1;
            end
        end
    end

    page_buffer #(.DEPTH(PAGE_BYTES), .DATA_W(8)) u_buf (
        .clk(clk), .rst_n(rst_n),
        .clr(wr_cmd && host_wdata[0] && !streaming),
        .wr_en(wr_buf && !streaming),
        .wr_data(host_wdata),
        .rd_idx(idx), .rd_data(buf_rd)
    );

    unlock_tracker #(.ADDR_W(ADDR_W)) u_unlock (
        .clk(clk), .rst_n(rst_n),
        .valid(direct_start), .consume(trigger),
        .wr_addr(addr_reg), .wr_data(host_wdata),
        .armed(armed)
    );

    flash_cycle_engine #(.ADDR_W(ADDR_W), .DATA_W(8),
                         .PULSE_CYC(PULSE_CYC), .GAP_CYC(GAP_CYC)) u_eng (
        .clk(clk), .rst_n(rst_n), .start(eng_start),
        .addr_in(eng_addr), .data_in(eng_data),
        .addr_out(flash_addr), .data_out(flash_dq),
        .we_n(flash_we_n), .ce_n(flash_ce_n),
        .busy(eng_busy), .cyc_done(eng_done)
    );

    a_r9_addr_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        streaming |=> $stable(addr_reg));
    a_r6_launch_armed: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(streaming) |-> ($past(armed) && $past(wr_hi)));
    a_r8_sent_at_end: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(page_sent) |-> ($past(streaming) && !streaming));
endmodule

// File: tb/flash_page_writer_test.sv
// Scoreboard bench: drivers push expected device cycles, a monitor pops
// and compares them as write-enable pulses appear.
module flash_page_writer_test;
    localparam int PULSE = 4;
    localparam int GAP   = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_wr = 1'b0;
    logic [2:0]  host_sel = '0;
    logic [7:0]  host_wdata = '0;
    logic [17:0] flash_addr;
    logic [7:0]  flash_dq;
    logic        flash_we_n, flash_ce_n, page_sent;

    int total = 0;
    int bad = 0;
    logic [25:0] expq [$];
    logic [7:0]  model [256];
    int          wptr = 0;
    logic [17:0] areg = '0;
    logic        prev_we = 1'b1;
    int          lowc = 0;

    always #5 clk = ~clk;

    flash_page_writer uut (
        .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_sel(host_sel),
        .host_wdata(host_wdata), .flash_addr(flash_addr), .flash_dq(flash_dq),
        .flash_we_n(flash_we_n), .flash_ce_n(flash_ce_n), .page_sent(page_sent)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic host_write(input logic [2:0] sel, input logic [7:0] d);
        @(negedge clk);
        host_wr = 1'b1; host_sel = sel; host_wdata = d;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic idle_wait();
        repeat (PULSE + GAP + 3) @(negedge clk);
    endtask

    task automatic set_addr(input logic [17:0] a);
        host_write(3'd2, a[7:0]);
        host_write(3'd3, a[15:8]);
        host_write(3'd4, {6'd0, a[17:16]});
        areg = a;
    endtask

    task automatic direct(input logic [7:0] d);
        expq.push_back({areg, d});
        host_write(3'd6, d);
        idle_wait();
    endtask

    task automatic unlock();
        set_addr(18'h05555); direct(8'hAA);
        set_addr(18'h02AAA); direct(8'h55);
        set_addr(18'h05555); direct(8'hA0);
    endtask

    task automatic buf_byte(input logic [7:0] d);
        host_write(3'd1, d);
        model[wptr] = d;
        wptr = (wptr + 1) % 256;
    endtask

    task automatic launch(input logic [17:0] base);
        for (int i = 0; i < 256; i++)
            expq.push_back({18'(base + 18'(i)), model[i]});
        set_addr(base);
    endtask

    task automatic wait_sent();
        for (int k = 0; k < 5000 && !page_sent; k++) @(negedge clk);
    endtask

    // Monitor: pops the scoreboard on each new pulse and times its width.
    always @(negedge clk) begin
        if (rst_n) begin
            if (!flash_we_n && prev_we) begin
                if (expq.size() == 0) begin
                    check(1'b0, "R7 unexpected device cycle", int'(flash_addr), 0);
                end else begin
                    logic [25:0] e;
                    e = expq.pop_front();
                    check(flash_addr == e[25:8], "R3/R7 cycle address", int'(flash_addr), int'(e[25:8]));
                    check(flash_dq == e[7:0], "R5/R7 cycle data", int'(flash_dq), int'(e[7:0]));
                    check(!flash_ce_n, "R5 chip enable low", int'(flash_ce_n), 0);
                end
                lowc = 1;
            end else if (!flash_we_n) begin
                lowc++;
            end else if (lowc > 0) begin
                check(lowc == PULSE, "R5 pulse width", lowc, PULSE);
                lowc = 0;
            end
            prev_we = flash_we_n;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        check(1'b0, "watchdog expired", 0, 1);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < 256; i++) model[i] = 8'h00;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset values
        check(flash_we_n && flash_ce_n, "R1 strobes idle", int'({flash_we_n, flash_ce_n}), 3);
        check(!page_sent, "R1 page_sent clear", int'(page_sent), 0);
        check(flash_addr == '0 && flash_dq == '0, "R1 address and data zero", int'(flash_addr), 0);

        // R3 address assembly, R5 direct write plus dropped back-to-back write
        set_addr(18'h21234);
        expq.push_back({areg, 8'h5A});
        host_write(3'd6, 8'h5A);
        host_write(3'd6, 8'hEE);
        idle_wait();
        check(expq.size() == 0, "R5 dropped write left queue", expq.size(), 0);

        // R4 address clear
        set_addr(18'h3ABCD);
        host_write(3'd5, 8'h00);
        areg = '0;
        direct(8'hC3);

        // R2 fill with pointer wrap (258 bytes)
        host_write(3'd0, 8'h01);
        wptr = 0;
        for (int j = 0; j < 258; j++) buf_byte(8'((j * 37 + 11) & 255));

        // R6 incomplete sequence: no stream
        set_addr(18'h05555); direct(8'hAA);
        set_addr(18'h02AAA); direct(8'h55);
        set_addr(18'h01000);
        repeat (40) @(negedge clk);
        check(!page_sent, "R6 no launch without full unlock", int'(page_sent), 0);
        check(expq.size() == 0, "R6 no stream cycles", expq.size(), 0);

        // R6/R7 full unlock and stream with address wrap
        unlock();
        launch(18'h3FF80);
        check(!page_sent, "R8 page_sent low during stream", int'(page_sent), 0);
        // R9 writes during stream ignored
        host_write(3'd2, 8'h11);
        host_write(3'd5, 8'h00);
        host_write(3'd1, 8'h99);
        host_write(3'd0, 8'h01);
        host_write(3'd6, 8'h77);
        wait_sent();
        repeat (3) @(negedge clk);
        check(page_sent, "R8 page_sent set at end", int'(page_sent), 1);
        check(expq.size() == 0, "R7 all 256 bytes streamed", expq.size(), 0);
        repeat (20) @(negedge clk);
        check(page_sent, "R8 page_sent holds", int'(page_sent), 1);

        // R9 address kept: direct write goes to the stream base
        direct(8'h3C);

        // R2 partial rewrite then second stream; R9 buffer untouched otherwise
        host_write(3'd0, 8'h01);
        wptr = 0;
        buf_byte(8'hD0);
        buf_byte(8'hD1);
        unlock();
        launch(18'h00100);
        @(negedge clk);
        check(!page_sent, "R8 page_sent cleared on new stream", int'(page_sent), 0);
        wait_sent();
        repeat (3) @(negedge clk);
        check(page_sent, "R8 second page sent", int'(page_sent), 1);
        check(expq.size() == 0, "R7 second stream complete", expq.size(), 0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule